// File: doc/BRIEF.md
# Cross-Lane Operand Permutation Network

This block rearranges one vector operand across the lanes of a 64-lane wave before that operand reaches the ALU. Each lane carries a 32-bit value. The lanes form 4 rows of 16 lanes, and each row splits into 4 banks of 4 lanes. A 9-bit control code picks the source lane for every destination lane. The available patterns are:

- a permutation inside each group of four lanes;
- a shift or rotate inside each row;
- a shift or rotate of the whole wave by one lane;
- a full-row or half-row mirror;
- two broadcast patterns.

The network is purely combinational. It returns the permuted value of every lane and a per-lane write enable. The write enable is cleared when:

- the lane's source falls outside its legal range, unless the bound-control flag is set;
- the lane's row is masked off;
- the lane's bank is masked off;
- the control code is not a defined one.

The ALU consumes the permuted operand, and the register file uses the write enables to decide which lanes commit a result. Both of those units sit outside this block.

Top module: `lanePermute`

## Requirements
- R1: With code bit 8 clear, code bits [2k+1:2k] name the lane within the same aligned group of four that feeds position k of that group (k = 0..3). Every source is valid.
- R2: Codes 0x101..0x10F (n = code[3:0]) give each lane the value from n lanes higher in the same row. A source beyond the row's last lane is invalid.
- R3: Codes 0x111..0x11F give each lane the value from n lanes lower in the same row. A source below the row's first lane is invalid.
- R4: Codes 0x121..0x12F rotate each row right by n: lane position p takes position (p-n) mod 16 of its own row. Every source is valid.
- R5: Code 0x130 takes lane+1, and lane 63 is invalid. Code 0x138 takes lane-1, and lane 0 is invalid. Code 0x134 takes (lane+1) mod 64. Code 0x13C takes (lane-1) mod 64.
- R6: Code 0x140 gives row position p the value of position 15-p in the same row. Code 0x141 gives lane L the value of lane L XOR 7.
- R7: Code 0x142 gives every lane of rows 1..3 the value of the last lane of the row below it, and row 0 keeps its own values. Code 0x143 gives all lanes 32..63 the value of lane 31, and lanes 0..31 keep their own values.
- R8: A lane with an invalid source outputs zero with its write enabled when boundCtrl is 1. When boundCtrl is 0, it outputs its own input value with its write disabled.
- R9: A lane's write enable is 0 when bit (lane/16) of rowMask is 0 or bit ((lane/4) mod 4) of bankMask is 0.
- R10: Every other code (0x100, 0x110, 0x120, 0x131..0x133, 0x135..0x137, 0x139..0x13B, 0x13D..0x13F, 0x144..0x1FF) passes each lane's own value through and drives every write enable to 0.
- R11: Outputs depend only on the present inputs, with no clock or state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctrlCode | input | 9 | Permutation control code |
| rowMask | input | 4 | Per-row write permission |
| bankMask | input | 4 | Per-bank write permission, applied in every row |
| boundCtrl | input | 1 | 1: invalid-source lanes write zero; 0: they do not write |
| srcData | input | 2048 | Operand, lane k in bits [32k+31:32k] |
| permData | output | 2048 | Permuted operand, same lane layout |
| laneWrEn | output | 64 | Per-lane write enable |

## Verification
The hardest case to reach is a lane whose source is invalid while its row and bank are both enabled. Only then does boundCtrl alone decide both the zero fill and the write enable. The bench walks all 512 control codes, three times each, with random data, random masks and random boundCtrl. Directed cases then pin the row-shift edges, the end lanes of the wave shifts and the all-enabled masks under both boundCtrl values. Unlisted codes are checked at the ports: the bench requires their outputs to equal the inputs and every write enable to be clear.

// File: rtl/lanePermutePkg.sv
package lanePermutePkg;

  localparam int ROW_LANES  = 16;
  localparam int BANK_LANES = 4;
  localparam int SHIFT_W    = $clog2(ROW_LANES);
  localparam int QSEL_W     = 2 * BANK_LANES;
  localparam int CODE_W     = 9;

  typedef enum logic [3:0] {
    MODE_IDENT,
    MODE_QUAD,
    MODE_RSHL,
    MODE_RSHR,
    MODE_RROR,
    MODE_WSHL,
    MODE_WSHR,
    MODE_WROL,
    MODE_WROR,
    MODE_MIRR,
    MODE_HMIRR,
    MODE_BC_ROW,
    MODE_BC_HALF
  } permMode_e;

  typedef struct packed {
    permMode_e            mode;
    logic [SHIFT_W-1:0]   amount;
    logic [QSEL_W-1:0]    quadSel;
    logic                 codeOk;
  } permCmd_t;

endpackage

// File: rtl/permDecode.sv
module permDecode
  import lanePermutePkg::*;
(
  input  logic [CODE_W-1:0] ctrlCode,
  output permCmd_t          cmd
);

  logic [3:0] group;
  logic [3:0] low;

  assign group = ctrlCode[7:4];
  assign low   = ctrlCode[3:0];

  always_comb begin
    cmd.mode    = MODE_IDENT;
    cmd.amount  = low[SHIFT_W-1:0];
    cmd.quadSel = ctrlCode[QSEL_W-1:0];
    cmd.codeOk  = 1'b0;
    if (!ctrlCode[8]) begin
      cmd.mode   = MODE_QUAD;
      cmd.codeOk = 1'b1;
    end else begin
      unique case (group)
        4'h0: if (low != 4'h0) begin cmd.mode = MODE_RSHL; cmd.codeOk = 1'b1; end
        4'h1: if (low != 4'h0) begin cmd.mode = MODE_RSHR; cmd.codeOk = 1'b1; end
        4'h2: if (low != 4'h0) begin cmd.mode = MODE_RROR; cmd.codeOk = 1'b1; end
        4'h3: begin
          unique case (low)
            4'h0: begin cmd.mode = MODE_WSHL; cmd.codeOk = 1'b1; end
            4'h4: begin cmd.mode = MODE_WROL; cmd.codeOk = 1'b1; end
            4'h8: begin cmd.mode = MODE_WSHR; cmd.codeOk = 1'b1; end
            4'hC: begin cmd.mode = MODE_WROR; cmd.codeOk = 1'b1; end
            default: ;
          endcase
        end
        4'h4: begin
          unique case (low)
            4'h0: begin cmd.mode = MODE_MIRR;    cmd.codeOk = 1'b1; end
            4'h1: begin cmd.mode = MODE_HMIRR;   cmd.codeOk = 1'b1; end
            4'h2: begin cmd.mode = MODE_BC_ROW;  cmd.codeOk = 1'b1; end
            4'h3: begin cmd.mode = MODE_BC_HALF; cmd.codeOk = 1'b1; end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  // R2/R3/R4: a row shift or rotate is never decoded with a zero amount
  always_comb begin
    if (!$isunknown(ctrlCode)) begin
      a_r2_row_amount_nonzero: assert (!((cmd.mode == MODE_RSHL || cmd.mode == MODE_RSHR ||
                                          cmd.mode == MODE_RROR) && cmd.amount == '0));
    end
  end

endmodule

// File: rtl/permLanes.sv
module permLanes
  import lanePermutePkg::*;
#(
  parameter int LANES  = 64,
  parameter int DATA_W = 32
) (
  input  permCmd_t                   cmd,
  input  logic [LANES/ROW_LANES-1:0] rowMask,
  input  logic [BANK_LANES-1:0]      bankMask,
  input  logic                       boundCtrl,
  input  logic [LANES*DATA_W-1:0]    srcData,
  output logic [LANES*DATA_W-1:0]    permData,
  output logic [LANES-1:0]           laneWrEn
);

  localparam int IDX_W   = $clog2(LANES);
  localparam int HALF_W  = LANES / 2;
  localparam int HROW    = ROW_LANES / 2;

  logic [DATA_W-1:0] srcArr [LANES];
  logic [LANES-1:0]  srcOkVec;

  for (genvar gu = 0; gu < LANES; gu++) begin : gUnpack
    assign srcArr[gu] = srcData[gu*DATA_W +: DATA_W];
  end

  for (genvar gl = 0; gl < LANES; gl++) begin : gLane
    localparam int ROW   = gl / ROW_LANES;
    localparam int POS   = gl % ROW_LANES;
    localparam int BANK  = POS / BANK_LANES;
    localparam int QPOS  = gl % BANK_LANES;
    localparam int RBASE = ROW * ROW_LANES;

    int               srcSel;
    logic             srcOk;
    logic [IDX_W-1:0] srcIdx;
    logic [DATA_W-1:0] picked;
    int               amt;

    always_comb begin
      amt    = int'(cmd.amount);
      srcSel = gl;
      srcOk  = 1'b1;
      unique case (cmd.mode)
        MODE_QUAD:   srcSel = gl - QPOS + int'(cmd.quadSel[2*QPOS +: 2]);
        MODE_RSHL:   if (POS + amt < ROW_LANES) srcSel = gl + amt; else srcOk = 1'b0;
        MODE_RSHR:   if (POS >= amt) srcSel = gl - amt; else srcOk = 1'b0;
        MODE_RROR:   srcSel = RBASE + ((POS + ROW_LANES - amt) % ROW_LANES);
        MODE_WSHL:   if (gl < LANES - 1) srcSel = gl + 1; else srcOk = 1'b0;
        MODE_WSHR:   if (gl > 0) srcSel = gl - 1; else srcOk = 1'b0;
        MODE_WROL:   srcSel = (gl + 1) % LANES;
        MODE_WROR:   srcSel = (gl + LANES - 1) % LANES;
        MODE_MIRR:   srcSel = RBASE + (ROW_LANES - 1 - POS);
        MODE_HMIRR:  srcSel = (gl - gl % HROW) + (HROW - 1 - gl % HROW);
        MODE_BC_ROW: srcSel = (ROW == 0) ? gl : RBASE - 1;
        MODE_BC_HALF: srcSel = (gl >= HALF_W) ? HALF_W - 1 : gl;
        default:     srcSel = gl;
      endcase
    end

    assign srcIdx = IDX_W'(srcSel);
    assign picked = srcArr[srcIdx];
    assign srcOkVec[gl] = srcOk;

    assign permData[gl*DATA_W +: DATA_W] =
      srcOk ? picked : (boundCtrl ? '0 : srcArr[gl]);
    assign laneWrEn[gl] =
      cmd.codeOk & (srcOk | boundCtrl) & rowMask[ROW] & bankMask[BANK];
  end

  // R7: upper half of the wave sees the middle lane under the half broadcast
  // R8: invalid sources in enabled rows and banks follow boundCtrl
  always_comb begin
    if (!$isunknown({cmd, boundCtrl, rowMask, bankMask, srcData})) begin
      if (cmd.mode == MODE_BC_HALF) begin
        a_r7_half_bcast: assert (permData[(LANES-1)*DATA_W +: DATA_W] == srcArr[HALF_W-1]);
      end
      if (cmd.mode == MODE_WSHL && boundCtrl) begin
        a_r8_bound_zero: assert (permData[(LANES-1)*DATA_W +: DATA_W] == '0);
      end
      if (cmd.mode == MODE_WSHR && !boundCtrl) begin
        a_r8_no_write: assert (!laneWrEn[0]);
      end
      if (cmd.mode == MODE_WROL || cmd.mode == MODE_QUAD) begin
        a_r5_all_valid: assert (&srcOkVec);
      end
    end
  end

endmodule

// File: rtl/lanePermute.sv
module lanePermute
  import lanePermutePkg::*;
#(
  parameter int LANES  = 64,
  parameter int DATA_W = 32
) (
  input  logic [CODE_W-1:0]          ctrlCode,
  input  logic [LANES/ROW_LANES-1:0] rowMask,
  input  logic [BANK_LANES-1:0]      bankMask,
  input  logic                       boundCtrl,
  input  logic [LANES*DATA_W-1:0]    srcData,
  output logic [LANES*DATA_W-1:0]    permData,
  output logic [LANES-1:0]           laneWrEn
);

  permCmd_t cmd;

  permDecode uDecode (
    .ctrlCode (ctrlCode),
    .cmd      (cmd)
  );

  permLanes #(.LANES(LANES), .DATA_W(DATA_W)) uLanes (
    .cmd       (cmd),
    .rowMask   (rowMask),
    .bankMask  (bankMask),
    .boundCtrl (boundCtrl),
    .srcData   (srcData),
    .permData  (permData),
    .laneWrEn  (laneWrEn)
  );

  always_comb begin
    if (!$isunknown({ctrlCode, rowMask, bankMask, boundCtrl, srcData})) begin
      if (ctrlCode > 9'h143) begin
        a_r10_unlisted_silent: assert (laneWrEn == '0 && permData == srcData);
      end
      if (rowMask == '0 || bankMask == '0) begin
        a_r9_masked_off: assert (laneWrEn == '0);
      end
      if (ctrlCode == 9'h140) begin
        a_r6_mirror_edge: assert (permData[DATA_W-1:0] == srcData[(ROW_LANES-1)*DATA_W +: DATA_W]);
      end
      if (ctrlCode == 9'h134) begin
        a_r5_wave_wrap: assert (permData[(LANES-1)*DATA_W +: DATA_W] == srcData[DATA_W-1:0]);
      end
    end
  end

endmodule

// File: tb/lanePermute_test.sv
module lanePermute_test;

  localparam int NL = 64;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [8:0]       ctrlCode = '0;
  logic [3:0]       rowMask = '0;
  logic [3:0]       bankMask = '0;
  logic             boundCtrl = 1'b0;
  logic [NL*DW-1:0] srcData = '0;
  logic [NL*DW-1:0] permData;
  logic [NL-1:0]    laneWrEn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lanePermute uut (
    .ctrlCode (ctrlCode), .rowMask (rowMask), .bankMask (bankMask),
    .boundCtrl (boundCtrl), .srcData (srcData),
    .permData (permData), .laneWrEn (laneWrEn)
  );

  function automatic string reqOf(int code);
    if (code < 256) return "R1";
    if (code >= 257 && code <= 271) return "R2";
    if (code >= 273 && code <= 287) return "R3";
    if (code >= 289 && code <= 303) return "R4";
    if (code == 304 || code == 308 || code == 312 || code == 316) return "R5";
    if (code == 320 || code == 321) return "R6";
    if (code == 322 || code == 323) return "R7";
    return "R10";
  endfunction

  function automatic void refLane(input int code, input int lane,
                                  output int src, output bit ok, output bit known);
    int p, base, n;
    p = lane % 16; base = lane - p; n = code % 16;
    src = lane; ok = 1; known = 1;
    if (code < 256) src = (lane / 4) * 4 + ((code >> (2 * (lane % 4))) & 3);
    else if (code >= 257 && code <= 271) begin if (p + n > 15) ok = 0; else src = lane + n; end
    else if (code >= 273 && code <= 287) begin if (p < n) ok = 0; else src = lane - n; end
    else if (code >= 289 && code <= 303) src = base + ((p - n + 16) % 16);
    else if (code == 304) begin if (lane == 63) ok = 0; else src = lane + 1; end
    else if (code == 312) begin if (lane == 0) ok = 0; else src = lane - 1; end
    else if (code == 308) src = (lane + 1) % 64;
    else if (code == 316) src = (lane + 63) % 64;
    else if (code == 320) src = base + 15 - p;
    else if (code == 321) src = lane ^ 7;
    else if (code == 322) src = (lane >= 16) ? base - 1 : lane;
    else if (code == 323) src = (lane >= 32) ? 31 : lane;
    else known = 0;
  endfunction

  task automatic applyAndCheck(input int code, input logic [3:0] rm, input logic [3:0] bm,
                               input logic bc, input string tag);
    logic [NL*DW-1:0] expD;
    logic [NL-1:0]    expW;
    int src; bit ok, known;
    @(negedge clk);
    ctrlCode = 9'(code); rowMask = rm; bankMask = bm; boundCtrl = bc;
    for (int l = 0; l < NL; l++) begin
      refLane(code, l, src, ok, known);
      expD[l*DW +: DW] = ok ? srcData[src*DW +: DW] : (bc ? 32'h0 : srcData[l*DW +: DW]);
      expW[l] = known && (ok || bc) && rm[l/16] && bm[(l/4)%4];
    end
    #5;
    checks++;
    if (permData !== expD) begin
      errors++;
      for (int l = 0; l < NL; l++) begin
        if (permData[l*DW +: DW] !== expD[l*DW +: DW]) begin
          $display("FAIL %s data code=%h lane %0d actual=%h expected=%h", tag, code, l,
                   permData[l*DW +: DW], expD[l*DW +: DW]);
          break;
        end
      end
    end
    checks++;
    if (laneWrEn !== expW) begin
      errors++;
      $display("FAIL %s wren code=%h actual=%h expected=%h", tag, code, laneWrEn, expW);
    end
  endtask

  task automatic randData();
    for (int l = 0; l < NL; l++) srcData[l*DW +: DW] = $urandom;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd7321);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 R11: zero operand through identity quad, all writes enabled
    srcData = '0;
    applyAndCheck(9'h0E4, 4'hF, 4'hF, 1'b0, "R1");
    randData();
    applyAndCheck(9'h0E4, 4'hF, 4'hF, 1'b0, "R11");
    // full sweep of every code with random data, masks, bound flag
    for (int code = 0; code < 512; code++) begin
      for (int t = 0; t < 3; t++) begin
        randData();
        applyAndCheck(code, 4'($urandom), 4'($urandom), 1'($urandom), reqOf(code));
      end
    end
    // R8: invalid-source lanes under both bound settings, all enabled
    randData();
    applyAndCheck(9'h117, 4'hF, 4'hF, 1'b1, "R8");
    applyAndCheck(9'h117, 4'hF, 4'hF, 1'b0, "R8");
    applyAndCheck(9'h130, 4'hF, 4'hF, 1'b1, "R8");
    applyAndCheck(9'h138, 4'hF, 4'hF, 1'b0, "R8");
    // R2 R3 extremes of shift amount
    applyAndCheck(9'h10F, 4'hF, 4'hF, 1'b0, "R2");
    applyAndCheck(9'h11F, 4'hF, 4'hF, 1'b1, "R3");
    applyAndCheck(9'h12F, 4'hF, 4'hF, 1'b0, "R4");
    // R9: row and bank masks
    applyAndCheck(9'h105, 4'hC, 4'hF, 1'b1, "R9");
    applyAndCheck(9'h105, 4'hF, 4'h5, 1'b1, "R9");
    applyAndCheck(9'h140, 4'h0, 4'hF, 1'b0, "R9");
    // R10: unlisted codes with everything enabled
    applyAndCheck(9'h100, 4'hF, 4'hF, 1'b1, "R10");
    applyAndCheck(9'h144, 4'hF, 4'hF, 1'b1, "R10");
    applyAndCheck(9'h1FF, 4'hF, 4'hF, 1'b0, "R10");
    // R7: broadcasts with all enabled
    applyAndCheck(9'h142, 4'hF, 4'hF, 1'b0, "R7");
    applyAndCheck(9'h143, 4'hF, 4'hF, 1'b0, "R7");
    // R6: mirrors
    applyAndCheck(9'h140, 4'hF, 4'hF, 1'b0, "R6");
    applyAndCheck(9'h141, 4'hF, 4'hF, 1'b0, "R6");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule